// File: doc/BRIEF.md
# Byte-Offset Battery RAM Access Adapter

This block connects a 32-bit host register bus to a small battery-backed RAM whose locations each hold one 16-bit cell. The host asks for a byte, word or longword read or write at a byte address. The adapter maps the address onto a cell and reproduces the irregular behaviour that the physical part shows when the byte offset is not aligned. The RAM itself is held inside the block as a register file.

A request lasts one cycle and is acknowledged in the following cycle. Read data is presented in the acknowledge cycle. The low two address bits choose the behaviour. The remaining bits choose the cell.

Top module: `nvram_bridge`

## Requirements
- R1: While reset is held and just after it is released, `ack` and `rdata` are 0, and cell i holds the low 16 bits of (i * 0x1357) XOR 0xC0DE.
- R2: `ack` is 1 in exactly the cycles that follow a cycle with `req` at 1. A write takes effect at the same edge, so a read requested in the next cycle sees the new value.
- R3: Cell index is addr >> 2. A write of size word (`size`=01), longword (10) or reserved (11) at offset 0 or 2 stores wdata[15:0] into that one cell and changes no other cell.
- R4: A byte write (`size`=00) at offset 0 or 2 replaces only bits [7:0] of the addressed cell with wdata[7:0]. Bits [15:8] are kept.
- R5: A write at offset 3 changes no cell, for every size.
- R6: A write at offset 1, of any size, clears the next higher cell to 0 and leaves the addressed cell unchanged. The cell above the last cell is cell 0.
- R7: Every in-range read returns the selected cell in both rdata[31:16] and rdata[15:0]. At offsets 0, 2 and 3, and for byte reads at offset 1, the selected cell is the addressed one.
- R8: Word and longword reads at offset 1 select the next higher cell instead, wrapping from the last cell to cell 0.
- R9: When addr >> 2 is not below the cell count, a read returns 0 and a write changes no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 00 byte, 01 word, 10 longword, 11 treated as longword |
| addr | input | ADDR_W (10) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when ack is 1 |
| ack | output | 1 | Acknowledge, one cycle after req |

## Verification
Random accesses mix all four offsets and all sizes. The addresses lean toward the last cell and toward out-of-range indices. Each read is compared with a bench model of the cell array, so the following cases are told apart:
- an offset-1 word read, which should fetch the cell above, from a byte read at the same offset, which should fetch the addressed cell;
- an offset-3 write, which should do nothing, from an offset-1 write, which should clear the cell above.

Directed cases cover the wrap from the top cell to cell 0, the byte-lane merge, and a longword write followed by reads of both neighbours. A final sweep reads back every cell, which shows any stray write that the random reads happened to miss.

// File: rtl/nvram_bridge_pkg.sv
package nvram_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } accessSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cellWrite;   // store into addressed cell
    logic byteLane;    // only low byte of the cell
    logic clearNext;   // zero the next higher cell
    logic readCapture; // load rdata
    logic readNext;    // read from next higher cell
    logic readBlank;   // out of range: return zero
  } strobe_t;

  function automatic logic [31:0] presetPattern(input int unsigned i);
    return (i * 32'h0000_1357) ^ 32'h0000_C0DE;
  endfunction

endpackage

// File: rtl/nvram_bridge_ctrl.sv
module nvram_bridge_ctrl
  import nvram_bridge_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CELL_COUNT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe,
  output logic              ack
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] cellIdx;
  logic [1:0]       byteOffset;
  logic             inRange;
  logic             isByte;

  assign cellIdx    = addr[ADDR_W-1:2];
  assign byteOffset = addr[1:0];
  assign inRange    = (32'(cellIdx) < 32'(CELL_COUNT));
  assign isByte     = (accessSize_e'(size) == SZ_BYTE);

  always_comb begin
    strobe             = '0;
    strobe.byteLane    = isByte;
    strobe.readNext    = (byteOffset == 2'd1) && !isByte;
    strobe.readBlank   = !inRange;
    strobe.readCapture = req && !we;
    if (req && we && inRange) begin
      unique case (byteOffset)
        2'd0, 2'd2: strobe.cellWrite = 1'b1;
        2'd1:       strobe.clearNext = 1'b1;
        default:    ; // offset 3: dropped
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ack <= 1'b0;
    else       ack <= req;
  end

  p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    req |=> ack);
  p_no_spurious_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    !req |=> !ack);

endmodule

// File: rtl/nvram_bridge_dp.sv
module nvram_bridge_dp
  import nvram_bridge_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CELL_COUNT = 64,
  parameter int CELL_W     = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CELL_W-1:0]   wdata,
  output logic [2*CELL_W-1:0] rdata
);
  localparam int SEL_W = $clog2(CELL_COUNT);

  logic [CELL_COUNT-1:0][CELL_W-1:0] cells;
  logic [SEL_W-1:0] cellSel;
  logic [SEL_W-1:0] nextSel;
  logic [SEL_W-1:0] readSel;

  assign cellSel = SEL_W'(addr >> 2);
  assign nextSel = (cellSel == SEL_W'(CELL_COUNT - 1)) ? '0 : cellSel + 1'b1;
  assign readSel = strobe.readNext ? nextSel : cellSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CELL_COUNT; i++)
        cells[i] <= CELL_W'(presetPattern(i));
    end else begin
      if (strobe.cellWrite) begin
        if (strobe.byteLane) cells[cellSel][7:0] <= wdata[7:0];
        else                 cells[cellSel]      <= wdata;
      end
      if (strobe.clearNext) cells[nextSel] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (strobe.readCapture)
      rdata <= strobe.readBlank ? '0 : {2{cells[readSel]}};
  end

  p_idle_keeps_cells_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cellWrite || strobe.clearNext) |=> $stable(cells));
  p_clear_is_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearNext |=> cells[$past(nextSel)] == '0);
  p_full_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cellWrite && !strobe.byteLane) |=> cells[$past(cellSel)] == $past(wdata));
  p_mirror_halves_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.readCapture |=> rdata[2*CELL_W-1:CELL_W] == rdata[CELL_W-1:0]);
  p_blank_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readCapture && strobe.readBlank) |=> rdata == '0);

endmodule

// File: rtl/nvram_bridge.sv
module nvram_bridge
  import nvram_bridge_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CELL_COUNT = 64,
  parameter int CELL_W     = 16,
  localparam int DATA_W    = 2 * CELL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);
  strobe_t strobe;
  logic    unusedWdataHi;

  assign unusedWdataHi = ^wdata[DATA_W-1:CELL_W];

  nvram_bridge_ctrl #(.ADDR_W(ADDR_W), .CELL_COUNT(CELL_COUNT)) ctrlInst (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .size(size), .addr(addr),
    .strobe(strobe), .ack(ack)
  );

  nvram_bridge_dp #(.ADDR_W(ADDR_W), .CELL_COUNT(CELL_COUNT), .CELL_W(CELL_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .wdata(wdata[CELL_W-1:0]), .rdata(rdata)
  );

endmodule

// File: tb/nvram_bridge_test.sv
`timescale 1ns/1ps
module nvram_bridge_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack;

  int checks = 0, errors = 0;
  logic [15:0] model [N];

  always #5 clk = ~clk;

  nvram_bridge uut (.clk(clk), .rstN(rstN), .req(req), .we(we), .size(size),
                    .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack));

  function automatic logic [15:0] preset(input int i);
    logic [31:0] v = (i * 32'h1357) ^ 32'hC0DE;
    return v[15:0];
  endfunction

  function automatic int nextOf(input int i);
    return (i == N - 1) ? 0 : i + 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [9:0] a, input logic [1:0] sz);
    int idx = int'(a >> 2);
    int sel;
    if (idx >= N) return 32'h0;
    sel = (a[1:0] == 2'd1 && sz != 2'b00) ? nextOf(idx) : idx;
    return {model[sel], model[sel]};
  endfunction

  function automatic string readTag(input logic [9:0] a, input logic [1:0] sz);
    if (int'(a >> 2) >= N) return "R9";
    if (a[1:0] == 2'd1 && sz != 2'b00) return "R8";
    return "R7";
  endfunction

  task automatic modelWrite(input logic [9:0] a, input logic [1:0] sz, input logic [31:0] d);
    int idx = int'(a >> 2);
    if (idx >= N) return;
    case (a[1:0])
      2'd0, 2'd2: if (sz == 2'b00) model[idx][7:0] = d[7:0]; else model[idx] = d[15:0];
      2'd1: model[nextOf(idx)] = 16'h0;
      default: ;
    endcase
  endtask

  // one access: drive at negedge, check ack/rdata at next negedge, ack low after
  task automatic access(input logic w, input logic [1:0] sz, input logic [9:0] a,
                        input logic [31:0] d, input string tag);
    logic [31:0] exp;
    exp = expRead(a, sz);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    check("R2 ack", {31'b0, ack}, 32'd1);
    if (w) modelWrite(a, sz, d);
    else   check(tag, rdata, exp);
    @(negedge clk);
    check("R2 idle", {31'b0, ack}, 32'd0);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [9:0] a, input string tag);
    access(1'b0, sz, a, 32'h0, tag);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < N; i++) rd(2'b10, 10'(i * 4), tag);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < N; i++) model[i] = preset(i);
    #1;
    check("R1 ack", {31'b0, ack}, 32'd0);
    check("R1 rdata", rdata, 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ack post", {31'b0, ack}, 32'd0);
    check("R1 rdata post", rdata, 32'h0);
    sweep("R1");

    // R3 longword write at offset 0, neighbours untouched
    access(1'b1, 2'b10, 10'd20, 32'hDEAD_BEEF, "R3");
    rd(2'b10, 10'd20, "R3");
    rd(2'b10, 10'd16, "R3");
    rd(2'b10, 10'd24, "R3");
    // R3 word write at offset 2
    access(1'b1, 2'b01, 10'd42, 32'h0000_1234, "R3");
    rd(2'b01, 10'd40, "R3");
    // R4 byte lane merge
    access(1'b1, 2'b00, 10'd8, 32'h0000_00AB, "R4");
    rd(2'b00, 10'd8, "R4");
    // R5 offset 3 dropped
    access(1'b1, 2'b10, 10'd31, 32'h5555_5555, "R5");
    rd(2'b10, 10'd28, "R5");
    rd(2'b10, 10'd32, "R5");
    // R6 offset 1 clears next, including wrap from top cell
    access(1'b1, 2'b01, 10'd13, 32'hFFFF_FFFF, "R6");
    rd(2'b10, 10'd12, "R6");
    rd(2'b10, 10'd16, "R6");
    access(1'b1, 2'b10, 10'(4 * (N - 1) + 1), 32'hFFFF_FFFF, "R6");
    rd(2'b10, 10'd0, "R6");
    access(1'b1, 2'b10, 10'd0, 32'h0000_7777, "R6");
    // R8 offset-1 word read of top cell wraps; R7 byte read stays
    rd(2'b01, 10'(4 * (N - 1) + 1), "R8");
    rd(2'b00, 10'(4 * (N - 1) + 1), "R7");
    rd(2'b11, 10'd5, "R8");
    rd(2'b10, 10'd7, "R7");
    // R9 out of range
    access(1'b1, 2'b10, 10'(4 * N), 32'h1111_1111, "R9");
    rd(2'b10, 10'(4 * N), "R9");
    rd(2'b01, 10'd1021, "R9");
    sweep("R9");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [9:0] a;
      logic [1:0] sz;
      int r = int'($urandom % 8);
      if (r < 5)       a = 10'($urandom % (4 * N));
      else if (r < 7)  a = 10'(4 * (N - 1) + ($urandom % 4));
      else             a = 10'($urandom);
      sz = 2'($urandom);
      if ($urandom % 2) access(1'b1, sz, a, $urandom, "R3");
      else              rd(sz, a, readTag(a, sz));
    end
    sweep("R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule